// File: doc/BRIEF.md
# Aperture Address Remapping Table

This block translates bus addresses that fall inside a fixed aperture window into physical addresses, one 4 KiB page at a time. Each page of the aperture owns one table entry. An entry carries a valid flag and a physical page frame. A lookup port takes an incoming address and returns its translation at once. If no translation applies, the port returns a fault.

Software reaches the table only through three registers on a small single-cycle bus:

- **Enable register.** Turns translation on and off.
- **Entry-address register.** Latches a full aperture address.
- **Entry-data register.** Moves an entry value into or out of the page selected by that latched address.

The aperture base and its page count are parameters.

Top module: `apt_remap`

## Requirements
- R1: After synchronous reset, translation is disabled, the entry-address register holds 0, every entry is invalid, and read data is 0.
- R2: A write to offset 0x0 stores bit 0 of the write data as the enable flag. A read of offset 0x0 returns the enable flag in bit 0 and zeros in bits 31:1.
- R3: A write to offset 0x4 stores the full 32-bit aperture address. A read of offset 0x4 returns the stored address.
- R4: A write to offset 0x8 updates the entry whose index is (latched address − base) >> 12. Bit 31 (valid) and bits 30:12 (page frame) are stored, and bits 11:0 are stored as zero.
- R5: A read request returns its data on the cycle after the request. A read of offset 0x8 returns the entry selected by the latched address. On any cycle not preceded by a read request, read data is 0.
- R6: If the latched address lies outside base … base + pages×4096 − 1, a write to offset 0x8 changes no entry and a read of offset 0x8 returns 0.
- R7: Writing an all-zero value to an entry unmaps its page, so lookups in that page fault.
- R8: A lookup address inside the aperture, with translation enabled and a valid entry, returns {0, entry bits 30:12, lookup bits 11:0} with fault low. The result is combinational, in the same cycle.
- R9: Every other lookup returns fault high and a physical address of 0. This covers translation disabled, an address outside the aperture, or an entry with bit 31 clear.
- R10: A read of any offset other than 0x0, 0x4 or 0x8 returns 0, and a write to such an offset has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| look_addr | input | 32 | Address to translate |
| look_phys | output | 32 | Translated physical address, or 0 on fault |
| look_fault | output | 1 | No translation available |

## Verification
The hardest situation to reach is an entry access whose latched address lies just outside the aperture. It only arises after a stray entry-address write, and it must leave every entry untouched. The stimulus latches the address one word below the base and then the first address past the end. For each, it writes entry data and reads it back, and the next lookups confirm that the first and last pages still hold their mappings. The stimulus also probes the last byte of the final page and the first byte beyond it. It also stores an entry whose frame is nonzero but whose valid bit is clear, so that a fault caused by the valid flag is told apart from one caused by an empty entry.

// File: rtl/apt_pkg.sv
package apt_pkg;

    localparam int unsigned PG_SHIFT   = 12;
    localparam int unsigned VLD_BIT    = 31;
    localparam logic [31:0] KEEP_MASK  = 32'hFFFF_F000;
    localparam logic [31:0] FRAME_MASK = 32'h7FFF_F000;
    localparam logic [31:0] OFF_MASK   = 32'h0000_0FFF;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_EADDR = 2'd1,
        SEL_EDATA = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic        valid;
        logic        write;
        reg_sel_e    sel;
        logic [31:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [31:0] phys;
        logic        fault;
    } xlat_t;

    function automatic reg_sel_e decode_off(input logic [3:0] off);
        case (off)
            4'h0:    return SEL_CTRL;
            4'h4:    return SEL_EADDR;
            4'h8:    return SEL_EDATA;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic in_aperture(input logic [31:0] a,
                                         input logic [31:0] base,
                                         input logic [31:0] pages);
        logic [31:0] d;
        d = a - base;
        return (a >= base) && ((d >> PG_SHIFT) < pages);
    endfunction

    function automatic logic [31:0] page_of(input logic [31:0] a,
                                            input logic [31:0] base);
        return (a - base) >> PG_SHIFT;
    endfunction

endpackage

// File: rtl/apt_table.sv
module apt_table
    import apt_pkg::*;
#(
    parameter int unsigned PAGES = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [31:0]      lk_data
);

    logic [31:0] ent [PAGES];

    for (genvar g = 0; g < PAGES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                ent[g] <= wr_data;
        end

        // R6: an entry changes only when the write port selects it
        p_entry_hold_r6: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(ent[g]));
    end

    always_comb begin
        rd_data = '0;
        lk_data = '0;
        for (int i = 0; i < PAGES; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = ent[i];
            if (lk_idx == IDX_W'(i)) lk_data = ent[i];
        end
    end

endmodule

// File: rtl/apt_regs.sv
module apt_regs
    import apt_pkg::*;
#(
    parameter logic [31:0] BASE  = 32'h5800_0000,
    parameter int unsigned PAGES = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic [31:0]      entry_rd,
    output logic             en,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [31:0]      wr_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rdata
);

    logic [31:0] eaddr;
    logic        ehit;

    assign ehit    = in_aperture(eaddr, BASE, 32'(PAGES));
    assign rd_idx  = IDX_W'(page_of(eaddr, BASE));
    assign wr_idx  = rd_idx;
    assign wr_data = req.wdata & KEEP_MASK;
    assign wr_en   = req.valid && req.write && req.sel == SEL_EDATA && ehit;

    always_ff @(posedge clk) begin
        if (rst) begin
            en    <= 1'b0;
            eaddr <= '0;
            rdata <= '0;
        end else begin
            rdata <= '0;
            if (req.valid && !req.write) begin
                case (req.sel)
                    SEL_CTRL:  rdata <= {31'b0, en};
                    SEL_EADDR: rdata <= eaddr;
                    SEL_EDATA: rdata <= ehit ? entry_rd : '0;
                    default:   rdata <= '0;
                endcase
            end
            if (req.valid && req.write) begin
                case (req.sel)
                    SEL_CTRL:  en    <= req.wdata[0];
                    SEL_EADDR: eaddr <= req.wdata;
                    default:   ;
                endcase
            end
        end
    end

    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.write && req.sel == SEL_CTRL) |=> en == $past(req.wdata[0]));

    p_rdata_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !(req.valid && !req.write) |=> rdata == '0);

    p_eaddr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(req.valid && req.write && req.sel == SEL_EADDR) |=> $stable(eaddr));

endmodule

// File: rtl/apt_lookup.sv
module apt_lookup
    import apt_pkg::*;
#(
    parameter logic [31:0] BASE  = 32'h5800_0000,
    parameter int unsigned PAGES = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [31:0]      look_addr,
    output logic [IDX_W-1:0] lk_idx,
    input  logic [31:0]      lk_data,
    output xlat_t            res
);

    logic hit;

    assign hit    = in_aperture(look_addr, BASE, 32'(PAGES));
    assign lk_idx = IDX_W'(page_of(look_addr, BASE));

    always_comb begin
        if (en && hit && lk_data[VLD_BIT]) begin
            res.phys  = (lk_data & FRAME_MASK) | (look_addr & OFF_MASK);
            res.fault = 1'b0;
        end else begin
            res.phys  = '0;
            res.fault = 1'b1;
        end
    end

    p_disabled_fault_r9: assert property (@(posedge clk) disable iff (rst)
        !en |-> res.fault);

    p_fault_zero_r9: assert property (@(posedge clk) disable iff (rst)
        res.fault |-> res.phys == '0);

    p_invalid_fault_r7: assert property (@(posedge clk) disable iff (rst)
        !lk_data[VLD_BIT] |-> res.fault);

    p_hit_offset_r8: assert property (@(posedge clk) disable iff (rst)
        !res.fault |-> (res.phys[11:0] == look_addr[11:0] && !res.phys[31]));

endmodule

// File: rtl/apt_remap.sv
module apt_remap
    import apt_pkg::*;
#(
    parameter logic [31:0] APER_BASE  = 32'h5800_0000,
    parameter int unsigned APER_PAGES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] look_addr,
    output logic [31:0] look_phys,
    output logic        look_fault
);

    localparam int unsigned IDX_W = (APER_PAGES > 1) ? $clog2(APER_PAGES) : 1;

    bus_req_t         req;
    logic             en;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [31:0]      wr_data;
    logic [IDX_W-1:0] rd_idx;
    logic [31:0]      rd_data;
    logic [IDX_W-1:0] lk_idx;
    logic [31:0]      lk_data;
    xlat_t            res;

    assign req.valid = bus_valid;
    assign req.write = bus_write;
    assign req.sel   = decode_off(bus_addr);
    assign req.wdata = bus_wdata;

    apt_regs #(.BASE(APER_BASE), .PAGES(APER_PAGES), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .req(req), .entry_rd(rd_data), .en(en),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rdata(bus_rdata)
    );

    apt_table #(.PAGES(APER_PAGES), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .lk_idx(lk_idx), .lk_data(lk_data)
    );

    apt_lookup #(.BASE(APER_BASE), .PAGES(APER_PAGES), .IDX_W(IDX_W)) u_look (
        .clk(clk), .rst(rst), .en(en), .look_addr(look_addr),
        .lk_idx(lk_idx), .lk_data(lk_data), .res(res)
    );

    assign look_phys  = res.phys;
    assign look_fault = res.fault;

endmodule

// File: tb/sim_apt_remap.sv
module sim_apt_remap;

    localparam logic [31:0] BASE = 32'h5800_0000;
    localparam int          N    = 16;
    localparam logic [31:0] ENDA = BASE + N * 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] look_addr = '0;
    logic [31:0] look_phys;
    logic        look_fault;

    always #5 clk = ~clk;

    apt_remap #(.APER_BASE(BASE), .APER_PAGES(N)) u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .look_addr(look_addr), .look_phys(look_phys), .look_fault(look_fault)
    );

    // behavioural reference state
    logic [31:0] m_tab [N];
    bit          m_en;
    logic [31:0] m_eaddr;
    logic [31:0] m_rd;

    int    checks = 0;
    int    errors = 0;
    bit    chk_on = 0;
    bit    done   = 0;
    string cur_req = "R1";

    function automatic bit m_hit(logic [31:0] a);
        longint x = longint'(a);
        return x >= longint'(BASE) && x < longint'(BASE) + longint'(N) * 4096;
    endfunction

    function automatic int m_idx(logic [31:0] a);
        return int'((a - BASE) / 4096);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_tab[i]) m_tab[i] = '0;
            m_en = 0; m_eaddr = '0; m_rd = '0;
        end else begin
            m_rd = '0;
            if (bus_valid && !bus_write) begin
                if (bus_addr == 4'h0) m_rd = {31'b0, m_en};
                else if (bus_addr == 4'h4) m_rd = m_eaddr;
                else if (bus_addr == 4'h8) m_rd = m_hit(m_eaddr) ? m_tab[m_idx(m_eaddr)] : '0;
            end
            if (bus_valid && bus_write) begin
                if (bus_addr == 4'h0) m_en = bus_wdata[0];
                else if (bus_addr == 4'h4) m_eaddr = bus_wdata;
                else if (bus_addr == 4'h8 && m_hit(m_eaddr))
                    m_tab[m_idx(m_eaddr)] = {bus_wdata[31:12], 12'h000};
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            logic [31:0] ep;
            logic        ef;
            checks++;
            if (bus_rdata !== m_rd) begin
                errors++;
                $display("FAIL %s rdata actual %h expected %h", cur_req, bus_rdata, m_rd);
            end
            if (m_en && m_hit(look_addr) && m_tab[m_idx(look_addr)][31]) begin
                ep = {1'b0, m_tab[m_idx(look_addr)][30:12], look_addr[11:0]};
                ef = 1'b0;
            end else begin
                ep = '0;
                ef = 1'b1;
            end
            checks++;
            if (look_phys !== ep || look_fault !== ef) begin
                errors++;
                $display("FAIL %s lookup %h actual %h/%b expected %h/%b",
                         cur_req, look_addr, look_phys, look_fault, ep, ef);
            end
        end
    end

    task automatic op(bit w, logic [3:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    task automatic look(logic [31:0] a);
        @(posedge clk); #1;
        look_addr = a;
    endtask

    task automatic put_entry(logic [31:0] a, logic [31:0] d);
        op(1, 4'h4, a);
        op(1, 4'h8, d);
        op(0, 4'h8, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk_on = 1;

        cur_req = "R1";
        op(0, 4'h0, '0);
        op(0, 4'h4, '0);
        op(0, 4'h8, '0);
        look(BASE); look(BASE + 32'h5123);

        cur_req = "R2";
        op(1, 4'h0, 32'h1);
        op(0, 4'h0, '0);
        op(1, 4'h0, 32'hFFFF_FFFE);
        op(0, 4'h0, '0);
        op(1, 4'h0, 32'h1);

        cur_req = "R3";
        op(1, 4'h4, BASE + 32'h3456);
        op(0, 4'h4, '0);

        cur_req = "R4";
        op(1, 4'h8, 32'h8123_4FFF);
        op(0, 4'h8, '0);
        for (int i = 0; i < N; i++)
            put_entry(BASE + i * 4096 + 32'h10, 32'h8000_0000 | ((i + 32'h100) << 12));

        cur_req = "R8";
        for (int i = 0; i < N; i++) look(BASE + i * 4096 + 32'h0ABC - i);
        look(ENDA - 1);
        look(BASE);

        cur_req = "R5";
        op(1, 4'h4, BASE + 32'h7000);
        op(0, 4'h8, '0);
        op(0, 4'h4, '0);
        op(0, 4'h0, '0);

        cur_req = "R6";
        put_entry(BASE - 4, 32'h8077_7000);
        put_entry(ENDA, 32'h8066_6000);
        look(BASE + 32'h10);
        look(ENDA - 32'h10);

        cur_req = "R7";
        put_entry(BASE + 32'h3000, 32'h0);
        look(BASE + 32'h3123);

        cur_req = "R9";
        put_entry(BASE + 32'h5000, 32'h0005_5000);
        look(BASE + 32'h5004);
        look(ENDA);
        look(BASE - 1);
        look(32'h0000_1234);
        op(1, 4'h0, 32'h0);
        look(BASE + 32'h6008);
        look(BASE + 32'h1008);
        op(1, 4'h0, 32'h1);
        look(BASE + 32'h1008);

        cur_req = "R10";
        op(1, 4'hC, 32'hFFFF_FFFF);
        op(1, 4'h1, 32'h0);
        op(0, 4'hC, '0);
        op(0, 4'h2, '0);
        op(0, 4'h0, '0);
        op(0, 4'h4, '0);
        look(BASE + 32'h2222);

        repeat (2) @(posedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule